// File: doc/BRIEF.md
# Four-Phase Handshake Rate Halver Chain

This block is a cascade of handshake rate halvers. It is modelled as synchronous logic. Each stage has two ports. On its passive port it receives a request and answers with an acknowledge. On its active port it issues a request and waits for an acknowledge. Both ports use four-phase, return-to-zero signalling.

For every complete handshake on its passive port, a stage performs two complete handshakes on its active port, and the two are interleaved with the phases of the passive handshake:
- While the passive request is high, the stage runs one full handshake on the active port. It then raises the active request again and waits for that request to be acknowledged. Only then does it acknowledge the passive port.
- After the passive request drops, the stage lowers its active request. It waits for the active acknowledge to fall, and then withdraws its own acknowledge.

The stages are wired in series: the active port of stage k feeds the passive port of stage k+1. The number of stages is a parameter, STAGES. One handshake on the outer port therefore produces 2^STAGES handshakes on the inner port. The chain can serve as a divider or counter of handshake events, or, read the other way, as a multiplier of them.

Top module: `hs_dup_chain`

## Requirements
- R1: While rst_n is low, and in the first cycle after it rises, in_ack and out_req are both 0.
- R2: One complete four-phase handshake on the outer port (in_req/in_ack) causes exactly 2^STAGES complete handshakes on the inner port (out_req/out_ack).
- R3: At the moment in_ack rises, exactly 2^STAGES-1 inner handshakes have completed, and out_req is 1 with out_ack already 1.
- R4: At the moment in_ack falls, out_req is 0 and exactly 2^STAGES inner handshakes have completed.
- R5: Every request output holds its level until the matching acknowledge input has followed it. Once raised, a request stays high while its acknowledge is low. Once lowered, it stays low while its acknowledge is high.
- R6: With in_req held low and no handshake in progress, out_req and in_ack stay 0 and no inner handshake occurs.
- R7: If out_ack never answers a raised out_req, then out_req stays 1 and in_ack stays 0.
- R8: A run of N outer handshakes yields N*2^STAGES inner handshakes, whatever the response latency of the inner partner.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_req | input | 1 | Request on the outer passive port |
| in_ack | output | 1 | Acknowledge on the outer passive port |
| out_req | output | 1 | Request on the inner active port |
| out_ack | input | 1 | Acknowledge on the inner active port |

## Verification
The assertions check the local protocol of each stage on every cycle:
- a request never moves ahead of its acknowledge;
- a stage raises its passive acknowledge only while its active request is high and acknowledged;
- a stage drops that acknowledge only after its active request has returned to zero;
- an idle stage with a low request stays silent.

The counting properties cannot be seen at a single stage and are left to the bench's scenarios. Those properties are the 2^STAGES multiplication, the exact count of 2^STAGES-1 when the outer acknowledge rises, and the count of N*2^STAGES across runs with different partner latencies. The same applies to the stall behaviour and to recovery through reset.

// File: rtl/hs_dup_pkg.sv
package hs_dup_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_AUP   = 3'd1,
        ST_ADN   = 3'd2,
        ST_BUP   = 3'd3,
        ST_HOLD  = 3'd4,
        ST_BDN   = 3'd5
    } dup_state_e;

    typedef struct packed {
        dup_state_e state;
        logic       req;
        logic       ack;
    } dup_regs_t;

    localparam dup_regs_t DUP_RESET = '{state: ST_IDLE, req: 1'b0, ack: 1'b0};

endpackage

// File: rtl/hs_dup_stage.sv
module hs_dup_stage
    import hs_dup_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pas_req,
    output logic pas_ack,
    output logic act_req,
    input  logic act_ack
);

    dup_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            ST_IDLE: if (pas_req && !act_ack) begin
                r_d.req   = 1'b1;
                r_d.state = ST_AUP;
            end
            ST_AUP: if (act_ack) begin
                r_d.req   = 1'b0;
                r_d.state = ST_ADN;
            end
            ST_ADN: if (!act_ack) begin
                r_d.req   = 1'b1;
                r_d.state = ST_BUP;
            end
            ST_BUP: if (act_ack) begin
                r_d.ack   = 1'b1;
                r_d.state = ST_HOLD;
            end
            ST_HOLD: if (!pas_req) begin
                r_d.req   = 1'b0;
                r_d.state = ST_BDN;
            end
            ST_BDN: if (!act_ack) begin
                r_d.ack   = 1'b0;
                r_d.state = ST_IDLE;
            end
            default: r_d = DUP_RESET;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= DUP_RESET;
        else        r_q <= r_d;
    end

    assign act_req = r_q.req;
    assign pas_ack = r_q.ack;

    // R5: a raised request waits for its acknowledge
    p_req_hold_hi_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (act_req && !act_ack) |=> act_req);

    // R5: a lowered request waits for its acknowledge to drop
    p_req_hold_lo_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!act_req && act_ack) |=> !act_req);

    // R3: the passive acknowledge rises only with the second active request granted
    p_ack_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pas_ack) |-> (act_req && $past(act_ack)));

    // R4: the passive acknowledge falls only after the active port returned to zero
    p_ack_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pas_ack) |-> (!act_req && !$past(act_ack)));

    // R6: an idle stage with no request stays silent
    p_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!pas_req && !pas_ack && !act_req && !act_ack) |=> !act_req);

endmodule

// File: rtl/hs_dup_chain.sv
module hs_dup_chain #(
    parameter int STAGES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_req,
    output logic in_ack,
    output logic out_req,
    input  logic out_ack
);

    logic [STAGES:0] req_w;
    logic [STAGES:0] ack_w;

    assign req_w[0]      = in_req;
    assign in_ack        = ack_w[0];
    assign out_req       = req_w[STAGES];
    assign ack_w[STAGES] = out_ack;

    for (genvar k = 0; k < STAGES; k++) begin : g_stage
        hs_dup_stage u_stage (
            .clk     (clk),
            .rst_n   (rst_n),
            .pas_req (req_w[k]),
            .pas_ack (ack_w[k]),
            .act_req (req_w[k+1]),
            .act_ack (ack_w[k+1])
        );
    end

    // R1: outputs are low in the first cycle out of reset
    p_reset_low_r1: assert property (@(posedge clk)
        (!rst_n) |=> (!in_ack && !out_req));

endmodule

// File: tb/hs_dup_chain_bench.sv
module hs_dup_chain_bench;

    localparam int  STAGES   = 3;
    localparam int  RATIO    = 1 << STAGES;
    localparam time CLK_HALF = 5;
    localparam int  WD_LIMIT = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_req = 1'b0;
    logic in_ack;
    logic out_req;
    logic out_ack = 1'b0;

    int errors = 0;
    int checks = 0;
    int done_cnt = 0;
    int resp_delay = 0;
    int resp_wait = 0;
    bit resp_freeze = 1'b0;
    bit done_clr = 1'b0;

    always #CLK_HALF clk = ~clk;

    hs_dup_chain #(.STAGES(STAGES)) u_hs_dup_chain (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_req  (in_req),
        .in_ack  (in_ack),
        .out_req (out_req),
        .out_ack (out_ack)
    );

    // inner partner: follows out_req after resp_delay cycles, counts completions
    always @(posedge clk) begin
        if (done_clr) begin
            done_cnt <= 0;
        end else if (!resp_freeze && (out_req != out_ack)) begin
            if (resp_wait >= resp_delay) begin
                out_ack   <= out_req;
                resp_wait <= 0;
                if (!out_req) done_cnt <= done_cnt + 1;
            end else begin
                resp_wait <= resp_wait + 1;
            end
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_count();
        @(negedge clk) done_clr = 1'b1;
        @(negedge clk) done_clr = 1'b0;
    endtask

    task automatic wait_ack(input logic lvl, input string req);
        int n = 0;
        while (in_ack !== lvl && n < 2000) begin
            @(negedge clk);
            n++;
        end
        check({req, " in_ack reached level"}, int'(in_ack === lvl), 1);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 in_ack in reset", int'(in_ack), 0);
        check("R1 out_req in reset", int'(out_req), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 in_ack after reset", int'(in_ack), 0);
        check("R1 out_req after reset", int'(out_req), 0);
    endtask

    task automatic t_single(input int dly);
        resp_delay = dly;
        clear_count();
        in_req = 1'b1;
        wait_ack(1'b1, "R3");
        check("R3 completions at ack rise", done_cnt, RATIO - 1);
        check("R3 out_req high at ack rise", int'(out_req), 1);
        check("R3 out_ack high at ack rise", int'(out_ack), 1);
        in_req = 1'b0;
        wait_ack(1'b0, "R4");
        check("R4 out_req low at ack fall", int'(out_req), 0);
        check("R4 completions at ack fall", done_cnt, RATIO);
        check("R2 total per handshake", done_cnt, RATIO);
    endtask

    task automatic t_idle();
        clear_count();
        repeat (50) @(negedge clk);
        check("R6 out_req idle", int'(out_req), 0);
        check("R6 in_ack idle", int'(in_ack), 0);
        check("R6 no inner activity", done_cnt, 0);
    endtask

    task automatic t_burst(input int n, input int dly);
        resp_delay = dly;
        clear_count();
        for (int i = 0; i < n; i++) begin
            in_req = 1'b1;
            wait_ack(1'b1, "R8");
            in_req = 1'b0;
            wait_ack(1'b0, "R8");
        end
        check("R8 burst total", done_cnt, n * RATIO);
    endtask

    task automatic t_stall();
        resp_delay = 0;
        clear_count();
        resp_freeze = 1'b1;
        in_req = 1'b1;
        repeat (40) @(negedge clk);
        check("R7 out_req held while stalled", int'(out_req), 1);
        check("R7 in_ack held low while stalled", int'(in_ack), 0);
        check("R5 out_req stable without ack", int'(out_req), 1);
        resp_freeze = 1'b0;
        wait_ack(1'b1, "R7");
        in_req = 1'b0;
        wait_ack(1'b0, "R7");
        check("R7 total after release", done_cnt, RATIO);
    endtask

    task automatic t_reset_mid();
        resp_delay = 2;
        in_req = 1'b1;
        repeat (7) @(negedge clk);
        in_req = 1'b0;
        rst_n = 1'b0;
        resp_freeze = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R1 out_req after mid reset", int'(out_req), 0);
        check("R1 in_ack after mid reset", int'(in_ack), 0);
        resp_freeze = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_single(0);
    endtask

    initial begin
        repeat (WD_LIMIT) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_idle();
        t_single(0);
        t_single(3);
        t_burst(4, 1);
        t_burst(3, 5);
        t_stall();
        t_idle();
        t_reset_mid();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule